// File: doc/BRIEF.md
# I2C Power-Controller Register Target

This block is the serial-bus face of a power-management controller. It watches the open-drain SCL and SDA lines, sampled into the system clock domain, and recognises START and STOP conditions. It answers its own 7-bit address, acknowledges bytes by pulling SDA low, and shifts data in and out most significant bit first. Behind the bit engine is a byte-wide register map of 186 locations with a single address pointer.

In a write transfer, the first data byte after the address loads the pointer. Later bytes reach storage only when the pointer selects the one writable location, and only then does the pointer step. Every other location keeps its reset value, and writes to it are acknowledged and then dropped. Read transfers stream bytes from the pointer upward. Once the pointer has left the map, reads return all ones and the pointer stays where it is. The usual access pattern is to write the pointer, issue a repeated START, and then read.

Top module: `pmic_i2c_regs`

## Requirements
- R1: A synchronous reset sets location 0x03 to 0x01, location 0x23 to 0x16 and location 0x40 to 0xD8. Every other location reads 0x00. The pointer becomes 0 and SDA is released.
- R2: The first byte after START carries the 7-bit address in bits 7..1 and the direction in bit 0, where 1 means read. The target pulls SDA low during the ninth clock only when the address equals the parameter (default 0x34). On any other address it leaves SDA released until the next START.
- R3: In a write transfer, the first data byte after the address byte loads the pointer and changes no location.
- R4: A later write byte is stored only when the pointer is 0x23, and the pointer then steps by one. At any other pointer value the byte is acknowledged and discarded, and the pointer keeps its value.
- R5: A read with the pointer below 186 returns the location at the pointer and steps the pointer by one.
- R6: A read with the pointer at 186 or above returns 0xFF and leaves the pointer unchanged.
- R7: START, repeated START and STOP re-arm the write byte count, so the next written byte is again a pointer byte. The pointer value survives all of these events.
- R8: Bytes travel most significant bit first. The target changes SDA only while SCL is low and holds it steady while SCL is high.
- R9: When the controller answers a read byte with a NACK (SDA high on the ninth clock), the target stops driving SDA until the next START.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Clocking after a STOP without a new START draws no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume that each SCL phase lasts at least a few system clocks. They also assume that the controller moves SDA only while SCL is low, except when it forms a START or STOP, and that it never signals START or STOP while the target holds SDA low. Under these conditions the target's SDA output can be required to hold steady throughout every SCL-high interval. The stimulus keeps each SCL phase at eight system clocks and changes SDA four clocks into the low phase. It issues repeated STARTs only after a byte the target has received, when SDA is free.

// File: rtl/pmic_i2c_regs.sv
module pmic_i2c_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         MAP_LEN  = 186,
  parameter logic [7:0] WR_REG   = 8'h23,
  parameter logic [7:0] WR_RST   = 8'h16,
  parameter logic [7:0] ID_REG   = 8'h03,
  parameter logic [7:0] ID_VAL   = 8'h01,
  parameter logic [7:0] IRQ_REG  = 8'h40,
  parameter logic [7:0] IRQ_VAL  = 8'hD8
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam logic [8:0] MAP_END = 9'(MAP_LEN);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK, S_RLOAD
  } state_t;

  state_t     state;
  logic [2:0] scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, ptr, wreg, rd_val;
  logic       first, rw;

  wire scl   = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda   = sda_p[1];
  wire sda_d = sda_p[2];

  wire start_det = scl && scl_d && sda_d && !sda;
  wire stop_det  = scl && scl_d && !sda_d && sda;
  wire scl_rise  = scl && !scl_d;
  wire scl_fall  = !scl && scl_d;
  wire in_map    = {1'b0, ptr} < MAP_END;
  wire bus_idle  = state == S_IDLE;
  wire ptr_set   = state == S_WBYTE && scl_fall && cnt == 4'd8 && first;

  always_comb begin
    if (!in_map)             rd_val = 8'hFF;
    else if (ptr == WR_REG)  rd_val = wreg;
    else if (ptr == ID_REG)  rd_val = ID_VAL;
    else if (ptr == IRQ_REG) rd_val = IRQ_VAL;
    else                     rd_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      wreg   <= WR_RST;
      first  <= 1'b1;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      cnt    <= '0;
      first  <= 1'b1;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      first  <= 1'b1;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WBYTE: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (state == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                state  <= S_AACK;
              end else begin
                state  <= S_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= S_WACK;
              if (first) begin
                ptr   <= sh;
                first <= 1'b0;
              end else if (ptr == WR_REG) begin
                wreg <= sh;
                ptr  <= ptr + 8'd1;
              end
            end
          end
        end
        S_WACK: if (scl_fall) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          state  <= S_WBYTE;
        end
        S_AACK, S_RLOAD: if (scl_fall) begin
          cnt <= '0;
          if (state == S_RLOAD || rw) begin
            sh     <= rd_val;
            sda_oe <= !rd_val[7];
            state  <= S_RBYTE;
            if (in_map) ptr <= ptr + 8'd1;
          end else begin
            sda_oe <= 1'b0;
            state  <= S_WBYTE;
          end
        end
        S_RBYTE: if (scl_fall) begin
          if (cnt == 4'd7) begin
            sda_oe <= 1'b0;
            state  <= S_RACK;
          end else begin
            cnt    <= cnt + 4'd1;
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= !sh[6];
          end
        end
        S_RACK: if (scl_rise) state <= sda ? S_IDLE : S_RLOAD;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pmic_i2c_regs_chk.sv
module pmic_i2c_regs_chk #(
  parameter int         MAP_LEN = 186,
  parameter logic [7:0] WR_REG  = 8'h23
) (
  input logic       clk,
  input logic       rst,
  input logic       scl,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       bus_idle,
  input logic       ptr_set,
  input logic [7:0] ptr,
  input logic [7:0] wreg
);

  localparam logic [8:0] MAP_END = 9'(MAP_LEN);

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl && !start_det && !stop_det) |=> $stable(sda_oe)); // R8

  AST_IDLE_RELEASES_SDA: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> !sda_oe); // R9

  AST_PTR_PARKED_PAST_END: assert property (@(posedge clk) disable iff (rst)
    (!ptr_set && ({1'b0, ptr} >= MAP_END)) |=> $stable(ptr)); // R6

  AST_PTR_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    !ptr_set |=> (ptr == $past(ptr) || ptr == $past(ptr) + 8'd1)); // R5

  AST_WRITE_ONLY_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    !$stable(wreg) |-> $past(ptr) == WR_REG); // R4

  AST_EVENT_REARMS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> !ptr_set); // R7

endmodule

bind pmic_i2c_regs pmic_i2c_regs_chk #(.MAP_LEN(MAP_LEN), .WR_REG(WR_REG)) u_chk (
  .clk(clk), .rst(rst), .scl(scl), .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .bus_idle(bus_idle), .ptr_set(ptr_set), .ptr(ptr), .wreg(wreg)
);

// File: tb/test_pmic_i2c_regs.sv
`timescale 1ns/1ps
module test_pmic_i2c_regs;
  localparam logic [6:0] ADDR = 7'h34;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_tb = 1'b1, sda_tb = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_tb & ~sda_oe;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int regs [0:185];
  int ptr;
  bit first;

  always #10 clk = ~clk;

  pmic_i2c_regs i_pmic_i2c_regs (
    .clk(clk), .rst(rst), .scl_i(scl_tb), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  function automatic void m_reset();
    for (int i = 0; i < 186; i++) regs[i] = 0;
    regs[8'h03] = 8'h01; regs[8'h23] = 8'h16; regs[8'h40] = 8'hD8;
    ptr = 0; first = 1;
  endfunction

  function automatic void m_write(input int b);
    if (first) begin ptr = b; first = 0; end
    else if (ptr == 8'h23) begin regs[ptr] = b; ptr++; end
  endfunction

  function automatic int m_read();
    int v;
    if (ptr < 186) begin v = regs[ptr]; ptr++; end
    else v = 8'hFF;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic bitc(input logic drv, input logic expd, output logic seen, inout int bad);
    sda_tb = drv;
    repeat (4) @(negedge clk);
    scl_tb = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (sda_oe !== expd) bad++;
      if (k == 3) seen = sda_line;
    end
    scl_tb = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    first = 1;
    sda_tb = 1'b1; repeat (4) @(negedge clk);
    scl_tb = 1'b1; repeat (4) @(negedge clk);
    sda_tb = 1'b0; repeat (4) @(negedge clk);
    scl_tb = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic bus_stop();
    first = 1;
    sda_tb = 1'b0; repeat (4) @(negedge clk);
    scl_tb = 1'b1; repeat (4) @(negedge clk);
    sda_tb = 1'b1; repeat (8) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    int bad = 0;
    logic s;
    for (int i = 7; i >= 0; i--) bitc(b[i], 1'b0, s, bad);
    bitc(1'b1, exp_ack, s, bad);
    chk(bad == 0, tag, exp_ack ? "ack/drive on sent byte" : "no drive on sent byte", bad, 0);
  endtask

  task automatic get_byte(input bit last, input string tag);
    int e, bad;
    logic s;
    logic [7:0] v;
    e = m_read(); bad = 0; v = '0;
    for (int i = 7; i >= 0; i--) begin
      bitc(1'b1, logic'(!e[i]), s, bad);
      v = {v[6:0], s};
    end
    bitc(logic'(last), 1'b0, s, bad);
    chk(v == e[7:0], tag, "read data", v, e);
    chk(bad == 0, tag, "read drive timing (R8)", bad, 0);
  endtask

  task automatic wr(input int n, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input string tag);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, tag);
    put_byte(a, 1'b1, tag); m_write(a);
    if (n > 1) begin put_byte(b, 1'b1, tag); m_write(b); end
    if (n > 2) begin put_byte(c, 1'b1, tag); m_write(c); end
    bus_stop();
  endtask

  task automatic rd(input int n, input string tag);
    bus_start();
    put_byte({ADDR, 1'b1}, 1'b1, tag);
    for (int i = 0; i < n; i++) get_byte(i == n - 1, tag);
    bus_stop();
  endtask

  initial begin
    m_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R1", "sda released after reset", sda_oe, 0);

    rd(5, "R1");
    wr(1, 8'h40, 8'h00, 8'h00, "R3");
    rd(1, "R7");

    wr(3, 8'h23, 8'hA5, 8'h77, "R4");
    rd(1, "R4");
    wr(2, 8'h3F, 8'h55, 8'h00, "R4");
    rd(2, "R4");

    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R7"); put_byte(8'h22, 1'b1, "R3"); m_write(8'h22);
    bus_start();
    put_byte({ADDR, 1'b1}, 1'b1, "R7");
    for (int i = 0; i < 3; i++) get_byte(i == 2, "R5");
    bus_stop();

    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R7"); put_byte(8'h23, 1'b1, "R7"); m_write(8'h23);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R7"); put_byte(8'h40, 1'b1, "R7"); m_write(8'h40);
    put_byte(8'h99, 1'b1, "R4"); m_write(8'h99);
    bus_stop();
    rd(1, "R7");

    wr(1, 8'hB8, 8'h00, 8'h00, "R6");
    rd(4, "R6");
    rd(1, "R6");
    wr(1, 8'hFE, 8'h00, 8'h00, "R6");
    rd(3, "R6");

    bus_start();
    put_byte({7'h35, 1'b0}, 1'b0, "R2");
    put_byte(8'h23, 1'b0, "R2");
    bus_stop();
    bus_start();
    put_byte({7'h35, 1'b1}, 1'b0, "R2");
    put_byte(8'hFF, 1'b0, "R2");
    bus_stop();
    rd(1, "R2");

    bus_start();
    put_byte({ADDR, 1'b1}, 1'b1, "R9");
    get_byte(1'b1, "R9");
    put_byte(8'hFF, 1'b0, "R9");
    bus_stop();

    scl_tb = 1'b0; repeat (4) @(negedge clk);
    put_byte({ADDR, 1'b0}, 1'b0, "R10");
    put_byte(8'h23, 1'b0, "R10");
    bus_stop();
    rd(1, "R10");

    wr(2, 8'h23, 8'h3C, 8'h00, "R4");
    rst = 1'b1; m_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R1", "sda released after second reset", sda_oe, 0);
    rd(4, "R1");
    wr(1, 8'h23, 8'h00, 8'h00, "R1");
    rd(1, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule